// File: doc/BRIEF.md
# SPI Clock-Chip Register Slave

This block is the device side of a serial link to a battery-backed clock chip. It presents a byte-addressed register file to an SPI master. The file holds seven time-of-day bytes, two alarm sets, a control byte, a read-only status byte, a charger-setting byte and a bank of general-purpose RAM. The block does no timekeeping. Every byte is stored as written and returned as stored.

A transaction is the window in which the chip enable is high. The first byte of the window is an address byte. Its top bit selects the direction and the lower seven bits select the starting register. Every later byte in the same window reads or writes the next register, so the clock can be loaded or dumped in one burst. The write-protect bit in the control byte locks every other location. The control byte itself has a two-step clear: the first write only releases write protect, and a second write is needed to change the remaining control bits.

All SPI pins are sampled into the system clock through two-flop synchronizers, and edges are detected on the synchronized signals. The SPI clock must therefore run well below the system clock.

Top module: `spi_clock_regs`

## Requirements
- R1: The first complete byte after the chip enable rises is the address byte. Bit 7 = 1 selects write and bit 7 = 0 selects read, and bits 6..0 give the register address. A single-byte write followed by a single-byte read of a writable location returns the written byte.
- R2: Each further byte in the same chip-enable window accesses the next address (burst), for both writes and reads.
- R3: Bits travel MSB first. MOSI is captured on the falling SCK edge. During a read data byte, MISO presents bit 7 before the first rising SCK edge and advances one bit after each later rising edge. MISO is 0 while the chip enable is low, during the address byte and during write bursts.
- R4: While control bit 6 (write protect, address 0x0F) is 1, writes to every address other than 0x0F are discarded, including the user RAM.
- R5: Control writable bits are 6, 2, 1 and 0 (mask 0x47), and the other bits read 0. While write protect is 1, a control write changes bit 6 only. While it is 0, a control write loads all writable bits.
- R6: The status byte at 0x10 is read-only and reads 0x00.
- R7: Addresses 0x12-0x1F, and addresses above the user RAM (0x40 and up at the default depth), read 0x00 and ignore writes.
- R8: The burst address wraps from 0x11 back to 0x00, and from the top of the user RAM (0x3F by default) back to 0x20.
- R9: A fall of the chip enable discards any partial byte and returns the block to the address phase, and a partial write byte is never stored.
- R10: After reset every location reads 0x00 except control, which reads 0x40 (write protected), and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are sampled by it |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ce | input | 1 | Active-high chip enable framing a transaction |
| spi_sck | input | 1 | SPI clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial read data to the master |

## Verification
The assertions assume that SCK and MOSI change only while CE is high. They also assume that each SCK level lasts several system clocks, so that a synchronized edge is never missed and a completed read byte reloads the shift register before the next rising edge. The bench keeps every SCK half-period at ten system clocks. It raises SCK and changes MOSI together, and it waits the same margin after any change of CE. The abort cases drop CE in the middle of a byte, but only while SCK is low.

// File: rtl/spi_clock_regs.sv
module spi_clock_regs #(
  parameter int RAM_DEPTH = 32,  // user RAM bytes from 0x20, 2..96
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_ce,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int         NCLK     = 18;
  localparam int         RAM_IW   = $clog2(RAM_DEPTH);
  localparam logic [6:0] CLK_LAST = 7'h11;
  localparam logic [6:0] CTRL_A   = 7'h0F;
  localparam logic [6:0] STAT_A   = 7'h10;
  localparam logic [6:0] RAM_BASE = 7'h20;
  localparam logic [6:0] RAM_LAST = 7'(32 + RAM_DEPTH - 1);
  localparam logic [7:0] CTRL_MSK = 8'h47;
  localparam logic [7:0] CTRL_RST = 8'h40;

  logic [SYNC_LEN:0]   sck_sh;
  logic [SYNC_LEN-1:0] ce_sh, mosi_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sh <= '0; ce_sh <= '0; mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[SYNC_LEN-1:0], spi_sck};
      ce_sh   <= {ce_sh[SYNC_LEN-2:0], spi_ce};
      mosi_sh <= {mosi_sh[SYNC_LEN-2:0], spi_mosi};
    end

  wire ce_s     = ce_sh[SYNC_LEN-1];
  wire mosi_s   = mosi_sh[SYNC_LEN-1];
  wire sck_rise = sck_sh[SYNC_LEN-1] & ~sck_sh[SYNC_LEN];
  wire sck_fall = ~sck_sh[SYNC_LEN-1] & sck_sh[SYNC_LEN];

  logic [2:0] bit_cnt;
  logic [6:0] shreg, addr;
  logic [7:0] tx;
  logic       have_addr, is_write, ld_tx;
  logic [NCLK-1:0][7:0]      clk_regs;
  logic [RAM_DEPTH-1:0][7:0] ram_q;

  wire [7:0] in_byte   = {shreg, mosi_s};
  wire       byte_done = ce_s & sck_fall & (bit_cnt == 3'd7);
  wire       wr_fire   = byte_done & have_addr & is_write;
  wire       rd_phase  = have_addr & ~is_write;
  wire       wp        = clk_regs[15][6];
  wire       in_clk    = addr <= CLK_LAST;
  wire       in_ram    = (addr >= RAM_BASE) && (addr <= RAM_LAST);
  wire [RAM_IW-1:0] ram_ix = RAM_IW'(addr - RAM_BASE);

  logic [7:0] rd_data;
  logic [6:0] next_addr;
  always_comb begin
    rd_data = 8'h00;
    if (in_clk)      rd_data = clk_regs[addr[4:0]];
    else if (in_ram) rd_data = ram_q[ram_ix];
    if (addr == CLK_LAST)      next_addr = 7'h00;
    else if (addr == RAM_LAST) next_addr = RAM_BASE;
    else                       next_addr = addr + 7'd1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; shreg <= '0; addr <= '0; tx <= '0;
      have_addr <= 1'b0; is_write <= 1'b0; ld_tx <= 1'b0;
    end else begin
      ld_tx <= 1'b0;
      if (ld_tx) tx <= rd_data;
      if (!ce_s) begin
        bit_cnt <= '0; have_addr <= 1'b0; is_write <= 1'b0;
      end else begin
        if (sck_rise && rd_phase && bit_cnt != 3'd0) tx <= {tx[6:0], 1'b0};
        if (sck_fall) begin
          shreg   <= in_byte[6:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            if (!have_addr) begin
              have_addr <= 1'b1;
              is_write  <= in_byte[7];
              addr      <= in_byte[6:0];
              ld_tx     <= ~in_byte[7];
            end else begin
              addr  <= next_addr;
              ld_tx <= ~is_write;
            end
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_regs     <= '0;
      clk_regs[15] <= CTRL_RST;
      ram_q        <= '0;
    end else if (wr_fire) begin
      if (addr == CTRL_A) begin
        if (wp) clk_regs[15][6] <= in_byte[6];
        else    clk_regs[15]    <= in_byte & CTRL_MSK;
      end else if (!wp) begin
        if (in_clk && addr != STAT_A) clk_regs[addr[4:0]] <= in_byte;
        else if (in_ram)              ram_q[ram_ix]       <= in_byte;
      end
    end

  assign spi_miso = ce_s & rd_phase & tx[7];

  p_wp_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wp && addr != CTRL_A) |=> ($stable(clk_regs) && $stable(ram_q)));
  p_ctrl_twostep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wp && addr == CTRL_A) |=> $stable(clk_regs[15][5:0]));
  p_clk_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && have_addr && addr == CLK_LAST) |=> (addr == 7'h00));
  p_ram_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && have_addr && addr == RAM_LAST) |=> (addr == RAM_BASE));
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (bit_cnt == 3'd0 && !have_addr));
  p_status_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr == STAT_A) |=> $stable(clk_regs[16]));
endmodule

// File: tb/test_spi_clock_regs.sv
module test_spi_clock_regs;
  localparam int H = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_clock_regs i_spi_clock_regs (
    .clk(clk), .rst_n(rst_n), .spi_ce(ce), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso));

  task automatic check(input int r, input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%02h expected=%02h", r, what, act, exp);
    end
  endtask

  task automatic begin_t();
    @(negedge clk); ce = 1'b1; repeat (H) @(negedge clk);
  endtask
  task automatic end_t();
    repeat (H) @(negedge clk); ce = 1'b0; repeat (H) @(negedge clk);
  endtask
  task automatic bits(input logic [7:0] v, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk); mosi = v[i]; sck = 1'b1;
      repeat (H) @(negedge clk); rx[i] = miso;
      sck = 1'b0; repeat (H) @(negedge clk);
    end
  endtask
  task automatic wr1(input logic [6:0] a, input logic [7:0] d, output logic [7:0] rx);
    logic [7:0] dummy;
    begin_t(); bits({1'b1, a}, 8, dummy); bits(d, 8, rx); end_t();
  endtask
  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] dummy;
    begin_t(); bits({1'b0, a}, 8, dummy); bits(8'h00, 8, d); end_t();
  endtask

  // {req, address, write data, expected read}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'h00, 8'h59, 8'h59}, {8'd1, 8'h11, 8'hA5, 8'hA5},
    {8'd1, 8'h20, 8'h3C, 8'h3C}, {8'd1, 8'h3F, 8'hC3, 8'hC3},
    {8'd6, 8'h10, 8'hFF, 8'h00}, {8'd7, 8'h15, 8'h77, 8'h00},
    {8'd7, 8'h40, 8'h12, 8'h00}, {8'd5, 8'h0F, 8'hFF, 8'h47},
    {8'd5, 8'h0F, 8'h00, 8'h07}, {8'd5, 8'h0F, 8'h00, 8'h00}};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, dm;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    check(10, {7'd0, miso}, 8'h00, "miso after reset");
    rd1(7'h0F, r); check(10, r, 8'h40, "control reset");
    rd1(7'h00, r); check(10, r, 8'h00, "time byte reset");
    // R4 write protect blocks time and RAM
    wr1(7'h05, 8'h33, dm); rd1(7'h05, r); check(4, r, 8'h00, "protected time write");
    wr1(7'h21, 8'h44, dm); rd1(7'h21, r); check(4, r, 8'h00, "protected RAM write");
    wr1(7'h0F, 8'h00, dm); rd1(7'h0F, r); check(5, r, 8'h00, "release protect");
    // table: R1 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      wr1(VEC[v][22:16], VEC[v][15:8], dm);
      rd1(VEC[v][22:16], r);
      check(int'(VEC[v][31:24]), r, VEC[v][7:0], $sformatf("vector %0d addr %02h", v, VEC[v][23:16]));
    end
    // R2 burst write and read
    begin_t(); bits(8'h80, 8, dm);
    for (int i = 0; i < 7; i++) bits(8'(8'h10 + i), 8, dm);
    end_t();
    begin_t(); bits(8'h00, 8, dm);
    for (int i = 0; i < 7; i++) begin
      bits(8'h00, 8, r); check(2, r, 8'(8'h10 + i), $sformatf("burst read %0d", i));
    end
    end_t();
    // R8 wrap in clock region (status write ignored, R6)
    begin_t(); bits(8'h90, 8, dm); bits(8'h99, 8, dm); bits(8'hAA, 8, dm); bits(8'hBB, 8, dm); end_t();
    begin_t(); bits(8'h10, 8, dm);
    bits(8'h00, 8, r); check(6, r, 8'h00, "status in burst");
    bits(8'h00, 8, r); check(8, r, 8'hAA, "byte at 0x11");
    bits(8'h00, 8, r); check(8, r, 8'hBB, "wrapped to 0x00");
    end_t();
    // R8 wrap in RAM
    begin_t(); bits(8'hBF, 8, dm); bits(8'h11, 8, dm); bits(8'h22, 8, dm); end_t();
    begin_t(); bits(8'h3F, 8, dm);
    bits(8'h00, 8, r); check(8, r, 8'h11, "RAM top");
    bits(8'h00, 8, r); check(8, r, 8'h22, "RAM wrapped to 0x20");
    end_t();
    // R3 MISO quiet during write data
    wr1(7'h06, 8'h5A, r); check(3, r, 8'h00, "miso during write");
    rd1(7'h06, r); check(3, r, 8'h5A, "MSB-first byte");
    // R4 protect blocks a burst write
    wr1(7'h0F, 8'h40, dm);
    begin_t(); bits(8'h82, 8, dm); bits(8'hEE, 8, dm); bits(8'hEE, 8, dm); end_t();
    rd1(7'h02, r); check(4, r, 8'h12, "protected burst 0x02");
    rd1(7'h03, r); check(4, r, 8'h13, "protected burst 0x03");
    wr1(7'h0F, 8'h00, dm);
    // R9 partial data byte dropped
    begin_t(); bits(8'h81, 8, dm); bits(8'hFF, 4, dm); end_t();
    rd1(7'h01, r); check(9, r, 8'h11, "partial write discarded");
    // R9 partial address byte, then a fresh transaction
    begin_t(); bits(8'h80, 5, dm); end_t();
    rd1(7'h04, r); check(9, r, 8'h14, "address phase restarted");
    check(3, {7'd0, miso}, 8'h00, "miso idle");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule